// File: doc/BRIEF.md
# Clock-Activity Auto-Wake Controller

This block decides whether an audio device runs or sits in software shutdown, based only on whether a usable bit clock and frame sync are present on its serial audio port. Auto-wake is selected by a 2-bit mode field. When both clocks are qualified as valid, the block requests power-up. When the clocks disappear, a shutdown command arrives, or an enabled clock error is reported while running, it takes the device down through an orderly power-down handshake.

While powered down, a selectable grace timer holds off clock-error checking. If the timer runs out and the clocks are still missing, the block emits a one-cycle pre-power-up clock-error pulse and drops into the low-current sleep state. When the timer is disabled, the block waits in its intermediate state without a time limit and never reaches low-current sleep. After a shutdown caused by the clocks themselves (loss or error), the block retries power-up on its own.

Timer lengths are counted in 0.1 ms ticks from a prescaler. Each clock-valid indication passes a stability filter before it is used.

Top module: `clk_wake_ctrl`

## Requirements
- R1: While reset is asserted, `pwr_active`, `pd_req`, `sleep_lp` and `pre_err` are all 0.
- R2: With `mode` other than 2'b11, the block never asserts `pwr_active`, even with both clocks valid. Leaving 2'b11 while active makes `pwr_active` 0 on the next cycle.
- R3: In auto-wake mode (`mode`=2'b11) with no shutdown request, `pwr_active` rises only once both `bclk_ok` and `fsync_ok` are qualified valid. One valid clock alone never wakes the block.
- R4: On entering auto-wake, `halt_code` selects a grace time in 0.1 ms ticks: 1=8, 2=32, 3=341, 4=683, 5=2560, 6=7680, 7=13000. If the clocks are still not valid at expiry, `sleep_lp` rises and `pre_err` is high for exactly one cycle, in the first cycle of `sleep_lp`.
- R5: With `halt_code`=0, the grace time is unlimited: `sleep_lp` and `pre_err` stay 0 for as long as the clocks stay invalid.
- R6: In low-current sleep, the arrival of both valid clocks brings the block to active.
- R7: A high `sw_shdn` or `hw_shdn` while active starts the power-down: in the next cycle `pd_req`=1 and `pwr_active`=0. No wake occurs while either request is held. Once both are released, the block wakes again if the clocks are valid.
- R8: With `err_chk_en`=1, a `clk_err` pulse while active starts the power-down (`pd_req`=1 in the next cycle). With `err_chk_en`=0, `clk_err` has no effect.
- R9: After a power-down caused by a clock error or by loss of the clocks, `pd_done` sends the block straight back to the grace state. It wakes by itself if the clocks are valid, or otherwise goes to sleep with a `pre_err` pulse at grace expiry.
- R10: A clock-valid change that lasts less than FILT_TICKS ticks is ignored and causes no wake.
- R11: `pd_req` stays high until `pd_done` is seen, and `pwr_active` stays 0 meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Operating mode; 2'b11 selects clock-driven auto-wake |
| bclk_ok | input | 1 | Bit clock present and valid (raw indication) |
| fsync_ok | input | 1 | Frame sync present and valid (raw indication) |
| err_chk_en | input | 1 | Enables shutdown on reported clock errors |
| halt_code | input | 3 | Grace-timer length select |
| hw_shdn | input | 1 | Hardware shutdown command |
| sw_shdn | input | 1 | Software shutdown command |
| clk_err | input | 1 | Clock error reported by the error detectors |
| pd_done | input | 1 | Power-down sequence finished |
| pwr_active | output | 1 | Request the device to be active |
| pd_req | output | 1 | Orderly power-down request |
| sleep_lp | output | 1 | Low-current software shutdown state |
| pre_err | output | 1 | One-cycle pre-power-up clock-error event |

## Verification
The bench builds the block with TICK_CYCLES=2 and FILT_TICKS=3, so one 0.1 ms tick lasts two clocks. This makes all seven grace lengths short enough to be measured end to end, including the longest one at 13000 ticks. The short filter lets a two-cycle glitch be shown to be rejected, while a steady clock is accepted within about ten cycles. The handshake, retry and command paths are then reached in a few dozen cycles each.

// File: rtl/clkwake_pkg.sv
package clkwake_pkg;

  // Grace counter width, wide enough for the longest code (13000 ticks)
  localparam int HALT_CW = 14;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GRACE  = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_PDN    = 3'd4
  } wake_state_e;

  // Grace length in 0.1 ms ticks; zero means no limit
  function automatic logic [HALT_CW-1:0] halt_limit(input logic [2:0] code);
    logic [HALT_CW-1:0] lim;
    case (code)
      3'd1:    lim = HALT_CW'(8);
      3'd2:    lim = HALT_CW'(32);
      3'd3:    lim = HALT_CW'(341);
      3'd4:    lim = HALT_CW'(683);
      3'd5:    lim = HALT_CW'(2560);
      3'd6:    lim = HALT_CW'(7680);
      3'd7:    lim = HALT_CW'(13000);
      default: lim = '0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/cw_tick_gen.sv
module cw_tick_gen #(
  parameter int TICK_CYCLES = 2400
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    tick_d = (cnt_q == LAST);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/cw_valid_filt.sv
module cw_valid_filt #(
  parameter int FILT_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic qual_o
);
  localparam int FW = $clog2(FILT_TICKS + 1);
  localparam logic [FW-1:0] LIM = FW'(FILT_TICKS - 1);

  logic          sync1_q, sync2_q;
  logic          qual_q, qual_d;
  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    qual_d = qual_q;
    cnt_d  = cnt_q;
    if (sync2_q == qual_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == LIM) begin
        qual_d = sync2_q;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      qual_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      qual_q  <= qual_d;
      cnt_q   <= cnt_d;
    end
  end

  assign qual_o = qual_q;

  // R10
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qual_q) |-> $past(tick_i))
    else $error("qualified level changed without a tick");
endmodule

// File: rtl/cw_halt_timer.sv
module cw_halt_timer
  import clkwake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] code_i,
  output logic       expired_o
);
  logic               run_q, run_d;
  logic [HALT_CW-1:0] cnt_q, cnt_d;
  logic [HALT_CW-1:0] lim_q, lim_d;
  logic               exp_q, exp_d;
  logic [HALT_CW-1:0] new_lim;

  always_comb begin
    new_lim = halt_limit(code_i);
    run_d   = run_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    exp_d   = 1'b0;
    if (start_i) begin
      run_d = (new_lim != '0);
      cnt_d = '0;
      lim_d = new_lim;
    end else if (stop_i) begin
      run_d = 1'b0;
    end else if (run_q && tick_i) begin
      if (cnt_q == lim_q - 1'b1) begin
        exp_d = 1'b1;
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
      exp_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;

  // R4
  exp_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> $past(tick_i) && $past(run_q))
    else $error("grace expiry without a running tick");
endmodule

// File: rtl/cw_wake_fsm.sv
module cw_wake_fsm
  import clkwake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en_i,
  input  logic off_req_i,
  input  logic clk_ok_i,
  input  logic clk_err_i,
  input  logic err_en_i,
  input  logic tmr_exp_i,
  input  logic pd_done_i,
  output logic tmr_start_o,
  output logic tmr_stop_o,
  output logic pwr_active_o,
  output logic pd_req_o,
  output logic sleep_lp_o,
  output logic pre_err_o
);
  wake_state_e state_q, state_d;
  logic        retry_q, retry_d;
  logic        pre_q, pre_d;
  logic        go;

  always_comb begin
    go          = auto_en_i && !off_req_i;
    state_d     = state_q;
    retry_d     = retry_q;
    pre_d       = 1'b0;
    tmr_start_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d     = ST_GRACE;
          tmr_start_o = 1'b1;
        end
      end
      ST_GRACE: begin
        if (!go)           state_d = ST_IDLE;
        else if (clk_ok_i) state_d = ST_ACTIVE;
        else if (tmr_exp_i) begin
          state_d = ST_SLEEP;
          pre_d   = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!go)           state_d = ST_IDLE;
        else if (clk_ok_i) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!go) begin
          state_d = ST_PDN;
          retry_d = 1'b0;
        end else if (!clk_ok_i || (clk_err_i && err_en_i)) begin
          state_d = ST_PDN;
          retry_d = 1'b1;
        end
      end
      ST_PDN: begin
        if (pd_done_i) begin
          if (retry_q && go) begin
            state_d     = ST_GRACE;
            tmr_start_o = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      retry_q <= 1'b0;
      pre_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
      pre_q   <= pre_d;
    end
  end

  assign tmr_stop_o   = (state_q != ST_GRACE);
  assign pwr_active_o = (state_q == ST_ACTIVE);
  assign pd_req_o     = (state_q == ST_PDN);
  assign sleep_lp_o   = (state_q == ST_SLEEP);
  assign pre_err_o    = pre_q;

  // R11
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req_o && !pd_done_i |=> pd_req_o && !pwr_active_o)
    else $error("power-down request dropped before done");

  // R2
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en_i |=> !pwr_active_o)
    else $error("active outside auto-wake mode");

  // R3
  wake_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_active_o) |-> $past(clk_ok_i))
    else $error("woke without qualified clocks");

  // R4
  pre_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_err_o |=> !pre_err_o)
    else $error("pre-power-up error longer than one cycle");

  // R7
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_req_o) |-> $past(pwr_active_o))
    else $error("power-down entered from a non-active state");
endmodule

// File: rtl/clk_wake_ctrl.sv
module clk_wake_ctrl
  import clkwake_pkg::*;
#(
  parameter int TICK_CYCLES = 2400,
  parameter int FILT_TICKS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       bclk_ok,
  input  logic       fsync_ok,
  input  logic       err_chk_en,
  input  logic [2:0] halt_code,
  input  logic       hw_shdn,
  input  logic       sw_shdn,
  input  logic       clk_err,
  input  logic       pd_done,
  output logic       pwr_active,
  output logic       pd_req,
  output logic       sleep_lp,
  output logic       pre_err
);
  localparam int NCLK = 2;

  logic [1:0]      rs_q;
  logic            rst_i_n;
  logic            tick;
  logic [NCLK-1:0] raw_ok;
  logic [NCLK-1:0] qual_ok;
  logic            tmr_start, tmr_stop, tmr_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  cw_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (tick)
  );

  assign raw_ok = {fsync_ok, bclk_ok};

  for (genvar gi = 0; gi < NCLK; gi++) begin : g_filt
    cw_valid_filt #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .tick_i (tick),
      .raw_i  (raw_ok[gi]),
      .qual_o (qual_ok[gi])
    );
  end

  cw_halt_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick_i    (tick),
    .start_i   (tmr_start),
    .stop_i    (tmr_stop),
    .code_i    (halt_code),
    .expired_o (tmr_exp)
  );

  cw_wake_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .auto_en_i    (mode == 2'b11),
    .off_req_i    (hw_shdn | sw_shdn),
    .clk_ok_i     (&qual_ok),
    .clk_err_i    (clk_err),
    .err_en_i     (err_chk_en),
    .tmr_exp_i    (tmr_exp),
    .pd_done_i    (pd_done),
    .tmr_start_o  (tmr_start),
    .tmr_stop_o   (tmr_stop),
    .pwr_active_o (pwr_active),
    .pd_req_o     (pd_req),
    .sleep_lp_o   (sleep_lp),
    .pre_err_o    (pre_err)
  );
endmodule

// File: tb/test_clk_wake_ctrl.sv
module test_clk_wake_ctrl;
  localparam int TCY = 2;
  localparam int FT  = 3;
  localparam int unsigned LIM_TBL [7] = '{8, 32, 341, 683, 2560, 7680, 13000};

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       bclk_ok, fsync_ok, err_chk_en;
  logic [2:0] halt_code;
  logic       hw_shdn, sw_shdn, clk_err, pd_done;
  logic       pwr_active, pd_req, sleep_lp, pre_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  clk_wake_ctrl #(.TICK_CYCLES(TCY), .FILT_TICKS(FT)) i_clk_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bclk_ok(bclk_ok), .fsync_ok(fsync_ok),
    .err_chk_en(err_chk_en), .halt_code(halt_code), .hw_shdn(hw_shdn),
    .sw_shdn(sw_shdn), .clk_err(clk_err), .pd_done(pd_done),
    .pwr_active(pwr_active), .pd_req(pd_req), .sleep_lp(sleep_lp), .pre_err(pre_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pd_ack();
    pd_done = 1'b1;
    cyc(1);
    pd_done = 1'b0;
  endtask

  task automatic to_idle();
    mode = 2'b00; bclk_ok = 1'b0; fsync_ok = 1'b0;
    cyc(20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt, pres, lo, hi;
    rst_n = 1'b0; mode = 2'b00; bclk_ok = 1'b0; fsync_ok = 1'b0; err_chk_en = 1'b1;
    halt_code = 3'd1; hw_shdn = 1'b0; sw_shdn = 1'b0; clk_err = 1'b0; pd_done = 1'b0;
    cyc(4);
    // R1 reset state
    check("R1 pwr_active", pwr_active, 0);
    check("R1 pd_req", pd_req, 0);
    check("R1 sleep_lp", sleep_lp, 0);
    check("R1 pre_err", pre_err, 0);
    rst_n = 1'b1;
    cyc(4);

    // R2 no wake outside auto mode
    bclk_ok = 1'b1; fsync_ok = 1'b1; mode = 2'b01;
    cyc(40);
    check("R2 no wake mode 01", pwr_active, 0);
    mode = 2'b10;
    cyc(10);
    check("R2 no wake mode 10", pwr_active, 0);

    // R4 grace length per code, walked from the table
    for (int k = 0; k < 7; k++) begin
      to_idle();
      halt_code = 3'(k + 1);
      mode = 2'b11;
      cnt = 0; pres = 0;
      while (!sleep_lp && cnt < int'(LIM_TBL[k]) * TCY + 100) begin
        cyc(1); cnt++;
        if (pre_err) pres++;
      end
      lo = (int'(LIM_TBL[k]) - 1) * TCY;
      hi = (int'(LIM_TBL[k]) + 1) * TCY + 4;
      check($sformatf("R4 code %0d sleep reached", k + 1), sleep_lp, 1);
      check($sformatf("R4 code %0d latency %0d in window", k + 1, cnt),
            int'(cnt >= lo && cnt <= hi), 1);
      check($sformatf("R4 code %0d pre_err at entry", k + 1), pres, 1);
      cyc(1);
      check($sformatf("R4 code %0d pre_err single", k + 1), pre_err, 0);
    end

    // R5 unlimited grace
    to_idle();
    halt_code = 3'd0; mode = 2'b11;
    pres = 0;
    for (int i = 0; i < 300; i++) begin
      cyc(1);
      if (sleep_lp || pre_err) pres++;
    end
    check("R5 no sleep/pre_err with code 0", pres, 0);

    // R3 one clock alone, then both
    bclk_ok = 1'b1;
    cyc(40);
    check("R3 bit clock alone no wake", pwr_active, 0);
    fsync_ok = 1'b1;
    cyc(20);
    check("R3 both clocks wake", pwr_active, 1);

    // R7 / R11 software shutdown
    sw_shdn = 1'b1;
    cyc(1);
    check("R7 sw pd_req", pd_req, 1);
    check("R7 sw pwr_active low", pwr_active, 0);
    cyc(10);
    check("R11 pd_req held", pd_req, 1);
    check("R11 pwr_active low while pd", pwr_active, 0);
    pd_ack();
    check("R11 pd_req released", pd_req, 0);
    cyc(30);
    check("R7 no wake while sw_shdn", pwr_active, 0);
    sw_shdn = 1'b0;
    cyc(5);
    check("R7 wake after sw release", pwr_active, 1);

    // R7 hardware shutdown
    hw_shdn = 1'b1;
    cyc(1);
    check("R7 hw pd_req", pd_req, 1);
    pd_ack();
    cyc(30);
    check("R7 no wake while hw_shdn", pwr_active, 0);
    hw_shdn = 1'b0;
    cyc(5);
    check("R7 wake after hw release", pwr_active, 1);

    // R8 clock error with enable off, then on
    err_chk_en = 1'b0; clk_err = 1'b1;
    cyc(5);
    check("R8 error ignored when disabled (active)", pwr_active, 1);
    check("R8 error ignored when disabled (pd_req)", pd_req, 0);
    clk_err = 1'b0; err_chk_en = 1'b1;
    cyc(1);
    clk_err = 1'b1;
    cyc(1);
    clk_err = 1'b0;
    check("R8 error starts power-down", pd_req, 1);
    pd_ack();
    cyc(4);
    // R9 retry with valid clocks
    check("R9 retry after error wakes", pwr_active, 1);

    // R9 clock loss shutdown, then retry leads to sleep
    halt_code = 3'd1;
    bclk_ok = 1'b0; fsync_ok = 1'b0;
    cnt = 0;
    while (!pd_req && cnt < 40) begin cyc(1); cnt++; end
    check("R9 clock loss starts power-down", pd_req, 1);
    pd_ack();
    cnt = 0; pres = 0;
    while (!sleep_lp && cnt < 100) begin
      cyc(1); cnt++;
      if (pre_err) pres++;
    end
    check("R9 retry grace ends in sleep", sleep_lp, 1);
    check("R9 retry grace pre_err", pres, 1);

    // R10 glitch shorter than the filter
    bclk_ok = 1'b1; fsync_ok = 1'b1;
    cyc(2);
    bclk_ok = 1'b0; fsync_ok = 1'b0;
    cyc(30);
    check("R10 glitch no wake", pwr_active, 0);
    check("R10 glitch stays asleep", sleep_lp, 1);

    // R6 wake from sleep
    bclk_ok = 1'b1; fsync_ok = 1'b1;
    cyc(20);
    check("R6 wake from sleep", pwr_active, 1);
    check("R6 sleep cleared", sleep_lp, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule